// File: doc/BRIEF.md
# Timer Tick Generator

This block turns one system clock into five per-channel tick enables for a timer. Two 8-bit prescalers each divide the clock for a group of channels. Channels 0 and 1 share the first prescaler, and channels 2 to 4 share the second. Each channel then has its own power-of-two divider. A 4-bit select code picks one of the divided rates, or it picks an external clock. The external clock is brought into the system clock domain, and each of its rising edges becomes a one-cycle pulse.

Every output is a single-cycle enable pulse in the system clock domain, never a derived clock. A channel counter downstream advances on each pulse it receives. Changing a prescaler field never cuts short the period that is already counting. The new value is taken up at the next terminal count, so no runt tick can appear.

Top module: `timer_tick_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all `tick` bits are 0 in the following cycle.
- R2: A prescaler field of value P gives one prescaler tick every P+1 clock cycles. Field `presc_cfg[7:0]` serves channels 0 and 1, and field `presc_cfg[15:8]` serves channels 2, 3 and 4.
- R3: The select code of channel c sits at `sel_cfg[4c+3:4c]`. A code s in the range 0..3 that is not marked external gives one channel tick every 2^(s+DIV_BASE) prescaler ticks. DIV_BASE defaults to 0, so with the defaults a channel ticks every (P+1)·2^s cycles.
- R4: Every channel tick is high for exactly one cycle. A tick from a divided code always falls in a cycle in which its group's prescaler ticks.
- R5: A new prescaler value is captured only at a terminal count. This applies even when the write arrives in the terminal-count cycle itself. The period that is in progress completes at its old length, and the periods after it use the new value.
- R6: A select code whose bit is set in EXT_MASK routes the synchronized external clock to the channel. The default mask marks code 4 only. Channels 0 and 1 use `ext_clk[0]`, and channels 2 to 4 use `ext_clk[1]`. Each rising edge gives exactly one pulse, which appears in the second cycle after the edge is driven.
- R7: A select code that is neither marked external nor in 0..3 (5 to 15 by default) gives no ticks at all.
- R8: Changing one group's prescaler field leaves the tick period of every channel in the other group unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_cfg | input | 16 | Two prescaler fields: group 0 in [7:0], group 1 in [15:8] |
| sel_cfg | input | 20 | Per-channel 4-bit select codes, channel c at [4c+3:4c] |
| ext_clk | input | 2 | Asynchronous external clocks for group 0 (bit 0) and group 1 (bit 1) |
| tick | output | 5 | One-cycle tick enables, one per channel |

## Verification
Two events can land in the same cycle: a prescaler terminal count and a software write of a new prescaler value. The bench provokes this by writing the field in the exact cycle before a tick is due, and also by writing in the middle of a period. In both cases the gap that is in progress must keep its old length, and the next gap must show the new one. Divided ticks and prescaler ticks also coincide by design. That alignment is judged by checking that each tick is a single cycle wide and that the pulse counts come out exact over fixed windows.

// File: rtl/tick_pkg.sv
// Shared constants and the channel-to-group mapping for the tick generator.
// Assumes exactly two prescaler groups, with the lower channels in group 0.
package tick_pkg;
    localparam int unsigned NUM_GRP = 2;

    // Group index of a channel, given the number of channels in group 0
    function automatic int grp_of(input int ch, input int grp0_count);
        return (ch < grp0_count) ? 0 : 1;
    endfunction
endpackage

// File: rtl/tick_prescaler.sv
// Programmable prescaler: emits a one-cycle pulse every ratio+1 cycles.
// Assumes the ratio input may change at any time. It is sampled only at
// terminal count, so the period in progress always finishes at its old length.
module tick_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;
    logic         tick_q;

    // Count up to the latched limit, then pulse and take up the new limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lim_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == lim_q) begin
            cnt_q  <= '0;
            lim_q  <= ratio;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;
endmodule

// File: rtl/ext_edge_sync.sv
// Brings an asynchronous clock into the system domain through two flops
// and turns each rising edge into a one-cycle pulse.
// Assumes the external clock has high and low phases of at least two system cycles.
module ext_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic tick_o
);
    logic s1_q, s2_q, s3_q;

    // Two-flop synchronizer, followed by one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign tick_o = s2_q & ~s3_q;
endmodule

// File: rtl/tick_chan_div.sv
// Per-channel power-of-two divider and source select.
// Assumes pre_tick is a one-cycle pulse. Code s gives 2^(s+BASE) pre-ticks per
// tick; codes set in EXT_MASK pass ext_tick; all other codes give no ticks.
module tick_chan_div #(
    parameter int SEL_W  = 4,
    parameter int STAGES = 4,
    parameter int BASE   = 0,
    parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick,
    input  logic             ext_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_o
);
    localparam int MAXEXP = STAGES - 1 + BASE;
    localparam int CW     = (MAXEXP > 0) ? MAXEXP : 1;

    logic [CW-1:0]     dcnt_q;
    logic [STAGES-1:0] div_hit;
    logic              tick_c;

    // Free-running divider advanced by each prescaler pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            dcnt_q <= '0;
        else if (pre_tick)
            dcnt_q <= dcnt_q + 1'b1;
    end

    // Each stage fires when its low divider bits are all ones
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int E = k + BASE;
        if (E == 0) begin : g_pass
            assign div_hit[k] = pre_tick;
        end else begin : g_div
            assign div_hit[k] = pre_tick & (&dcnt_q[E-1:0]);
        end
    end

    // Source select: external clock, a divided stage, or nothing
    always_comb begin
        tick_c = 1'b0;
        if (EXT_MASK[sel])
            tick_c = ext_tick;
        else
            for (int k = 0; k < STAGES; k++)
                if (sel == SEL_W'(k))
                    tick_c = div_hit[k];
    end

    assign tick_o = tick_c;
endmodule

// File: rtl/timer_tick_gen.sv
// Top level: two group prescalers, two external clock synchronizers and one
// divider/select slice per channel. Assumes configuration is static, or that
// it is changed with the effects stated in the brief.
module timer_tick_gen #(
    parameter int NUM_CH     = 5,
    parameter int PRE_W      = 8,
    parameter int SEL_W      = 4,
    parameter int GRP0_CH    = 2,
    parameter int DIV_STAGES = 4,
    parameter int DIV_BASE   = 0,
    parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 'h10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*PRE_W-1:0]      presc_cfg,
    input  logic [NUM_CH*SEL_W-1:0] sel_cfg,
    input  logic [1:0]              ext_clk,
    output logic [NUM_CH-1:0]       tick
);
    import tick_pkg::*;

    logic [NUM_GRP-1:0] pre_tick;
    logic [NUM_GRP-1:0] ext_tick;

    // One prescaler and one external synchronizer per group
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tick_prescaler #(.W(PRE_W)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .ratio  (presc_cfg[g*PRE_W +: PRE_W]),
            .tick_o (pre_tick[g])
        );
        ext_edge_sync u_ext (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (ext_clk[g]),
            .tick_o   (ext_tick[g])
        );
    end

    // One divider/select slice per channel, fed by its group's sources
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int G = grp_of(c, GRP0_CH);
        tick_chan_div #(
            .SEL_W    (SEL_W),
            .STAGES   (DIV_STAGES),
            .BASE     (DIV_BASE),
            .EXT_MASK (EXT_MASK)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .pre_tick (pre_tick[G]),
            .ext_tick (ext_tick[G]),
            .sel      (sel_cfg[c*SEL_W +: SEL_W]),
            .tick_o   (tick[c])
        );
    end
endmodule

// File: rtl/timer_tick_gen_chk.sv
// Assertion checker for timer_tick_gen, attached with bind.
// Assumes the group split and encodings that are stated in the brief.
module timer_tick_gen_chk #(
    parameter int NUM_CH     = 5,
    parameter int PRE_W      = 8,
    parameter int SEL_W      = 4,
    parameter int GRP0_CH    = 2,
    parameter int DIV_STAGES = 4,
    parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 'h10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2*PRE_W-1:0]      presc_cfg,
    input logic [NUM_CH*SEL_W-1:0] sel_cfg,
    input logic [NUM_CH-1:0]       tick,
    input logic [1:0]              pre_tick,
    input logic [1:0]              ext_tick
);
    import tick_pkg::*;

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (tick == '0));

    for (genvar g = 0; g < 2; g++) begin : g_grp
        // R5/R2: after a tick whose captured field is nonzero, the next cycle is quiet
        p_presc_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_tick[g] && presc_cfg[g*PRE_W +: PRE_W] != '0
             && $stable(presc_cfg[g*PRE_W +: PRE_W])) |=> !pre_tick[g]);
        p_ext_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ext_tick[g] |=> !ext_tick[g]);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int G = grp_of(c, GRP0_CH);
        logic [SEL_W-1:0] code;
        assign code = sel_cfg[c*SEL_W +: SEL_W];

        p_sync_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[c] && !EXT_MASK[code]) |-> pre_tick[G]);
        p_dead_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!EXT_MASK[code] && int'(code) >= DIV_STAGES) |-> !tick[c]);
        p_ext_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
            EXT_MASK[code] |-> (tick[c] == ext_tick[G]));
    end
endmodule

bind timer_tick_gen timer_tick_gen_chk #(
    .NUM_CH     (NUM_CH),
    .PRE_W      (PRE_W),
    .SEL_W      (SEL_W),
    .GRP0_CH    (GRP0_CH),
    .DIV_STAGES (DIV_STAGES),
    .EXT_MASK   (EXT_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_cfg (presc_cfg),
    .sel_cfg   (sel_cfg),
    .tick      (tick),
    .pre_tick  (pre_tick),
    .ext_tick  (ext_tick)
);

// File: tb/timer_tick_gen_tb_top.sv
// Directed bench: one task per scenario, judged on tick gaps and pulse counts.
module timer_tick_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] presc_cfg = '0;
    logic [19:0] sel_cfg = '0;
    logic [1:0]  ext_clk = '0;
    logic [4:0]  tick;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    timer_tick_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_cfg (presc_cfg),
        .sel_cfg   (sel_cfg),
        .ext_clk   (ext_clk),
        .tick      (tick)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run is counted as a failure and still reports
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_sel(input int c, input logic [3:0] code);
        sel_cfg[c*4 +: 4] = code;
    endtask

    // Cycles until the next tick of channel c, sampled at falling edges
    task automatic gap(input int c, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick[c] && n < 3000);
    endtask

    task automatic period_is(input int c, input int exp, input string tag);
        int n;
        gap(c, n);
        gap(c, n);
        gap(c, n);
        check(tag, n, exp);
    endtask

    task automatic count_ticks(input int c, input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick[c]) n++;
        end
    endtask

    task automatic t_reset;
        int bad = 0;
        rst_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i > 0 && tick != '0) bad++;
        end
        check("R1 ticks held low in reset", bad, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_ratios;
        presc_cfg = 16'h0201;
        set_sel(0, 0); set_sel(1, 3); set_sel(2, 1); set_sel(3, 2); set_sel(4, 0);
        period_is(0, 2,  "R2 group0 P=1 code0");
        period_is(4, 3,  "R2 group1 P=2 code0");
        period_is(1, 16, "R3 code3 on P=1");
        period_is(2, 6,  "R3 code1 on P=2");
        period_is(3, 12, "R3 code2 on P=2");
        set_sel(0, 2); set_sel(1, 1); set_sel(2, 3); set_sel(3, 0); set_sel(4, 2);
        period_is(0, 8,  "R3 code2 on P=1");
        period_is(1, 4,  "R3 code1 on P=1");
        period_is(2, 24, "R3 code3 on P=2");
        period_is(3, 3,  "R3 code0 on P=2");
        period_is(4, 12, "R3 code2 on P=2 ch4");
    endtask

    task automatic t_pulse_width;
        int n;
        presc_cfg[7:0] = 8'd3;
        set_sel(0, 1);
        period_is(0, 8, "R4 period before width check");
        @(negedge clk);
        check("R4 tick low the cycle after", int'(tick[0]), 0);
        count_ticks(0, 79, n);
        check("R4 pulses in 80-cycle window", n, 10);
    endtask

    task automatic t_reload;
        int n;
        set_sel(0, 0);
        presc_cfg[7:0] = 8'd9;
        period_is(0, 10, "R5 settle at P=9");
        // write mid-period
        for (int i = 0; i < 5; i++) @(negedge clk);
        presc_cfg[7:0] = 8'd2;
        gap(0, n);
        check("R5 mid write keeps old gap", n + 5, 10);
        gap(0, n);
        check("R5 new gap after mid write", n, 3);
        presc_cfg[7:0] = 8'd9;
        period_is(0, 10, "R5 resettle at P=9");
        // write in the terminal-count cycle
        for (int i = 0; i < 9; i++) @(negedge clk);
        presc_cfg[7:0] = 8'd4;
        gap(0, n);
        check("R5 terminal-cycle write keeps old gap", n + 9, 10);
        gap(0, n);
        check("R5 new gap after terminal-cycle write", n, 5);
    endtask

    task automatic t_group_indep;
        presc_cfg = 16'h0201;
        set_sel(0, 0); set_sel(4, 0);
        period_is(4, 3, "R8 group1 before change");
        presc_cfg[7:0] = 8'd5;
        period_is(4, 3, "R8 group1 after group0 change");
        period_is(0, 6, "R8 group0 took new value");
    endtask

    task automatic t_ext;
        int n;
        presc_cfg = 16'h0000;
        set_sel(0, 4); set_sel(1, 0); set_sel(2, 4);
        ext_clk = 2'b00;
        for (int i = 0; i < 6; i++) @(negedge clk);
        ext_clk[0] = 1'b1;
        @(negedge clk);
        check("R6 no pulse one cycle after edge", int'(tick[0]), 0);
        @(negedge clk);
        check("R6 pulse two cycles after edge", int'(tick[0]), 1);
        @(negedge clk);
        check("R6 pulse lasts one cycle", int'(tick[0]), 0);
        for (int i = 0; i < 3; i++) @(negedge clk);
        ext_clk[0] = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        n = 0;
        for (int e = 0; e < 4; e++) begin
            ext_clk[0] = 1'b1;
            for (int i = 0; i < 3; i++) begin @(negedge clk); if (tick[0]) n++; end
            ext_clk[0] = 1'b0;
            for (int i = 0; i < 3; i++) begin @(negedge clk); if (tick[0]) n++; end
        end
        check("R6 one pulse per ext0 edge", n, 4);
        count_ticks(2, 10, n);
        check("R6 ch2 ignores ext0", n, 0);
        n = 0;
        for (int e = 0; e < 2; e++) begin
            ext_clk[1] = 1'b1;
            for (int i = 0; i < 3; i++) begin @(negedge clk); if (tick[2]) n++; end
            ext_clk[1] = 1'b0;
            for (int i = 0; i < 3; i++) begin @(negedge clk); if (tick[2]) n++; end
        end
        check("R6 one pulse per ext1 edge", n, 2);
    endtask

    task automatic t_dead_codes;
        int n;
        presc_cfg = 16'h0000;
        set_sel(1, 5); set_sel(2, 15); set_sel(3, 8);
        count_ticks(1, 200, n);
        check("R7 code5 silent", n, 0);
        count_ticks(2, 200, n);
        check("R7 code15 silent", n, 0);
        count_ticks(3, 200, n);
        check("R7 code8 silent", n, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ratios();
        t_pulse_width();
        t_reload();
        t_group_indep();
        t_ext();
        t_dead_codes();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule